// File: doc/BRIEF.md
# Stream Beat Fetch Unit with End-of-Packet Check

This unit is the execute-stage engine for a processor's custom "read one word from a stream" instructions. When the pipeline issues such an instruction, the unit raises its ready line on a single AXI4-Stream slave port. It takes exactly one beat, then hands the data word and the destination register index back to the pipeline with a one-cycle completion pulse.

Each instruction carries three flags. The first selects whether it waits for data or gives up at once. The second enables an end-of-packet check. The third gives the TLAST value the instruction expects on the beat it receives. If the check is enabled and the received TLAST differs from the expected value, in either direction, the completion carries a synchronous exception flag and a cause code that says which way the mismatch went. The beat is consumed and its data is returned even when the exception fires. The pipeline holds further issues while the stall output is high.

In waiting mode the instruction stalls until a beat arrives. In non-waiting mode with no beat offered, it completes after one pending cycle with a no-data flag (a carry-style status) and leaves the stream untouched.

Top module: `strm_get_unit`

## Requirements
- R1: During and right after reset, `s_tready`, `stall`, `done` and `exc_valid` are low, and `exc_cause` is 0.
- R2: An issue is accepted only while `stall` is low. From the cycle after acceptance, `stall` and `s_tready` are high until the operation completes. In the completion cycle, and whenever no operation is pending, `s_tready` is low.
- R3: A beat is consumed in a cycle where `s_tvalid` and `s_tready` are both high. In the next cycle `done` is high for exactly one cycle, with `done_data` equal to the consumed TDATA, `done_rd` equal to the issued register index, and `done_nodata` low.
- R4: A waiting-mode operation (`issue_blocking`=1) keeps `stall` and `s_tready` high, and `done` low, for as many cycles as `s_tvalid` stays low.
- R5: A non-waiting operation (`issue_blocking`=0) that sees `s_tvalid` low in its pending cycle completes in the next cycle with `done_nodata`=1, `done_data`=0 and no exception. It consumes no beat: `s_tready` is low afterwards, even if `s_tvalid` rises.
- R6: With `issue_chk_en`=1 and `issue_exp_last`=1, a consumed beat with TLAST=0 completes with `exc_valid`=1 and `exc_cause`=2'b01 (end of packet missing).
- R7: With `issue_chk_en`=1 and `issue_exp_last`=0, a consumed beat with TLAST=1 completes with `exc_valid`=1 and `exc_cause`=2'b10 (unexpected end of packet).
- R8: With `issue_chk_en`=0, or when TLAST equals `issue_exp_last`, completion carries `exc_valid`=0 and `exc_cause`=2'b00.
- R9: When an exception is raised, `done` and `done_data` still carry the consumed beat in the same cycle as `exc_valid`.
- R10: An issue presented while `stall` is high is ignored. The pending operation's register index and flags stay as issued, which shows in `done_rd` and in the exception outcome.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issue_valid | input | 1 | Stream-read instruction issues this cycle |
| issue_blocking | input | 1 | 1 = wait for data, 0 = return at once if empty |
| issue_chk_en | input | 1 | Enable the end-of-packet check |
| issue_exp_last | input | 1 | Expected TLAST value of the beat |
| issue_rd | input | RD_W | Destination register index |
| stall | output | 1 | Operation pending; pipeline must hold |
| s_tdata | input | DATA_W | Stream data |
| s_tvalid | input | 1 | Stream beat offered |
| s_tlast | input | 1 | Stream end-of-packet marker |
| s_tready | output | 1 | Unit accepts a beat |
| done | output | 1 | One-cycle completion pulse |
| done_rd | output | RD_W | Register index for write-back |
| done_data | output | DATA_W | Data word for write-back |
| done_nodata | output | 1 | Non-waiting operation found no data |
| exc_valid | output | 1 | Stream exception with this completion |
| exc_cause | output | 2 | 01 = TLAST missing, 10 = TLAST unexpected |

## Verification
The bench crosses waiting and non-waiting mode, check enabled and disabled, both expected-TLAST values and both received-TLAST values. Each combination runs with the beat ready at once and with the beat arriving two cycles late. The immediate cases separate the two mismatch directions from matching and unchecked beats. The late cases separate stalling from the no-data return and show that a beat offered after a no-data return is not taken. During a late wait, a stray issue with flipped flags and a different register index shows whether the pending operation's state can be overwritten.

// File: rtl/strm_get_pkg.sv
package strm_get_pkg;

    typedef enum logic [1:0] {
        XC_NONE         = 2'b00,
        XC_LAST_MISSING = 2'b01,
        XC_LAST_EXTRA   = 2'b10
    } strm_xc_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_PEND = 1'b1
    } get_state_e;

    typedef struct packed {
        logic blocking;
        logic chk_en;
        logic exp_last;
    } get_flags_t;

    function automatic strm_xc_e classify_last(
        input logic chk_en,
        input logic exp_last,
        input logic got_last
    );
        strm_xc_e r;
        r = XC_NONE;
        if (chk_en && exp_last && !got_last) r = XC_LAST_MISSING;
        if (chk_en && !exp_last && got_last) r = XC_LAST_EXTRA;
        return r;
    endfunction

endpackage

// File: rtl/strm_get_ctrl.sv
module strm_get_ctrl
    import strm_get_pkg::*;
#(
    parameter int RD_W = 5
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            issue_valid,
    input  get_flags_t      issue_flags,
    input  logic [RD_W-1:0] issue_rd,
    input  logic            s_tvalid,
    output logic            s_tready,
    output logic            pending,
    output logic            fire,
    output logic            finish,
    output logic            empty,
    output get_flags_t      op_flags,
    output logic [RD_W-1:0] op_rd
);
    get_state_e state_q;
    logic       accept;

    assign pending  = (state_q == ST_PEND);
    assign accept   = issue_valid && !pending;
    assign s_tready = pending;
    assign fire     = pending && s_tvalid;
    assign empty    = pending && !s_tvalid && !op_flags.blocking;
    assign finish   = fire || empty;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            op_flags <= '0;
            op_rd    <= '0;
        end else if (accept) begin
            state_q  <= ST_PEND;
            op_flags <= issue_flags;
            op_rd    <= issue_rd;
        end else if (finish) begin
            state_q  <= ST_IDLE;
        end
    end
endmodule

// File: rtl/strm_last_check.sv
module strm_last_check
    import strm_get_pkg::*;
(
    input  logic       fire,
    input  get_flags_t op_flags,
    input  logic       got_last,
    output strm_xc_e   xc_kind
);
    always_comb begin
        xc_kind = XC_NONE;
        if (fire) xc_kind = classify_last(op_flags.chk_en, op_flags.exp_last, got_last);
    end
endmodule

// File: rtl/strm_get_result.sv
module strm_get_result
    import strm_get_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int RD_W   = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              finish,
    input  logic              fire,
    input  logic              empty,
    input  logic [DATA_W-1:0] beat_data,
    input  logic [RD_W-1:0]   op_rd,
    input  strm_xc_e          xc_kind,
    output logic              done,
    output logic [RD_W-1:0]   done_rd,
    output logic [DATA_W-1:0] done_data,
    output logic              done_nodata,
    output logic              exc_valid,
    output logic [1:0]        exc_cause
);
    always_ff @(posedge clk) begin
        if (rst) begin
            done        <= 1'b0;
            done_rd     <= '0;
            done_data   <= '0;
            done_nodata <= 1'b0;
            exc_valid   <= 1'b0;
            exc_cause   <= 2'b00;
        end else begin
            done        <= finish;
            done_nodata <= finish && empty;
            exc_valid   <= finish && (xc_kind != XC_NONE);
            exc_cause   <= finish ? xc_kind : XC_NONE;
            if (finish) begin
                done_rd   <= op_rd;
                done_data <= fire ? beat_data : '0;
            end
        end
    end
endmodule

// File: rtl/strm_get_unit.sv
module strm_get_unit
    import strm_get_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int RD_W   = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              issue_valid,
    input  logic              issue_blocking,
    input  logic              issue_chk_en,
    input  logic              issue_exp_last,
    input  logic [RD_W-1:0]   issue_rd,
    output logic              stall,
    input  logic [DATA_W-1:0] s_tdata,
    input  logic              s_tvalid,
    input  logic              s_tlast,
    output logic              s_tready,
    output logic              done,
    output logic [RD_W-1:0]   done_rd,
    output logic [DATA_W-1:0] done_data,
    output logic              done_nodata,
    output logic              exc_valid,
    output logic [1:0]        exc_cause
);
    get_flags_t      in_flags;
    get_flags_t      op_flags;
    logic [RD_W-1:0] op_rd;
    logic            fire, finish, empty;
    strm_xc_e        xc_kind;

    assign in_flags = '{blocking: issue_blocking, chk_en: issue_chk_en, exp_last: issue_exp_last};

    strm_get_ctrl #(.RD_W(RD_W)) ctrl_i (
        .clk(clk), .rst(rst),
        .issue_valid(issue_valid), .issue_flags(in_flags), .issue_rd(issue_rd),
        .s_tvalid(s_tvalid), .s_tready(s_tready), .pending(stall),
        .fire(fire), .finish(finish), .empty(empty),
        .op_flags(op_flags), .op_rd(op_rd)
    );

    strm_last_check chk_last_i (
        .fire(fire), .op_flags(op_flags), .got_last(s_tlast), .xc_kind(xc_kind)
    );

    strm_get_result #(.DATA_W(DATA_W), .RD_W(RD_W)) res_i (
        .clk(clk), .rst(rst),
        .finish(finish), .fire(fire), .empty(empty),
        .beat_data(s_tdata), .op_rd(op_rd), .xc_kind(xc_kind),
        .done(done), .done_rd(done_rd), .done_data(done_data),
        .done_nodata(done_nodata), .exc_valid(exc_valid), .exc_cause(exc_cause)
    );
endmodule

// File: rtl/strm_get_chk.sv
module strm_get_chk #(
    parameter int DATA_W = 32,
    parameter int RD_W   = 5
) (
    input logic              clk,
    input logic              rst,
    input logic              stall,
    input logic [DATA_W-1:0] s_tdata,
    input logic              s_tvalid,
    input logic              s_tlast,
    input logic              s_tready,
    input logic              done,
    input logic [DATA_W-1:0] done_data,
    input logic              done_nodata,
    input logic              exc_valid,
    input logic [1:0]        exc_cause
);
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R3
    AST_BEAT_TO_DONE: assert property (@(posedge clk) disable iff (rst)
        (s_tvalid && s_tready) |=> (done && !done_nodata && done_data == $past(s_tdata))); // R3
    AST_DONE_FROM_PEND: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(stall)); // R2
    AST_NODATA_CLEAN: assert property (@(posedge clk) disable iff (rst)
        done_nodata |-> (done && done_data == '0 && !exc_valid)); // R5
    AST_EXC_WITH_DATA: assert property (@(posedge clk) disable iff (rst)
        exc_valid |-> (done && !done_nodata && $countones(exc_cause) == 1)); // R9
    AST_EXC_MISSING: assert property (@(posedge clk) disable iff (rst)
        (exc_valid && exc_cause == 2'b01) |-> !$past(s_tlast)); // R6
    AST_EXC_EXTRA: assert property (@(posedge clk) disable iff (rst)
        (exc_valid && exc_cause == 2'b10) |-> $past(s_tlast)); // R7
endmodule

bind strm_get_unit strm_get_chk #(.DATA_W(DATA_W), .RD_W(RD_W)) sva_i (
    .clk(clk), .rst(rst), .stall(stall), .s_tdata(s_tdata), .s_tvalid(s_tvalid),
    .s_tlast(s_tlast), .s_tready(s_tready), .done(done), .done_data(done_data),
    .done_nodata(done_nodata), .exc_valid(exc_valid), .exc_cause(exc_cause)
);

// File: tb/strm_get_unit_tb.sv
`timescale 1ns/1ps
module strm_get_unit_tb_top;
    localparam int DATA_W = 32;
    localparam int RD_W   = 5;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              issue_valid = 1'b0, issue_blocking = 1'b0;
    logic              issue_chk_en = 1'b0, issue_exp_last = 1'b0;
    logic [RD_W-1:0]   issue_rd = '0;
    logic              stall;
    logic [DATA_W-1:0] s_tdata = '0;
    logic              s_tvalid = 1'b0, s_tlast = 1'b0;
    logic              s_tready;
    logic              done;
    logic [RD_W-1:0]   done_rd;
    logic [DATA_W-1:0] done_data;
    logic              done_nodata, exc_valid;
    logic [1:0]        exc_cause;

    int checks = 0;
    int failures = 0;

    always #2.5 clk = ~clk;

    strm_get_unit #(.DATA_W(DATA_W), .RD_W(RD_W)) dut_i (
        .clk(clk), .rst(rst),
        .issue_valid(issue_valid), .issue_blocking(issue_blocking),
        .issue_chk_en(issue_chk_en), .issue_exp_last(issue_exp_last),
        .issue_rd(issue_rd), .stall(stall),
        .s_tdata(s_tdata), .s_tvalid(s_tvalid), .s_tlast(s_tlast), .s_tready(s_tready),
        .done(done), .done_rd(done_rd), .done_data(done_data),
        .done_nodata(done_nodata), .exc_valid(exc_valid), .exc_cause(exc_cause)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic run_op(input bit blk, input bit chk, input bit exl, input bit lst,
                          input int dly, input logic [31:0] d, input logic [4:0] rd);
        bit arrives;
        bit xc;
        logic [1:0] cause;
        arrives = (dly == 0) || blk;
        xc      = arrives && chk && (exl != lst);
        cause   = xc ? (exl ? 2'b01 : 2'b10) : 2'b00;
        @(negedge clk);
        issue_valid = 1'b1; issue_blocking = blk; issue_chk_en = chk;
        issue_exp_last = exl; issue_rd = rd; s_tvalid = 1'b0;
        @(negedge clk);
        issue_valid = 1'b0;
        check("R2 tready while pending", {31'd0, s_tready}, 32'd1);
        check("R2 stall while pending", {31'd0, stall}, 32'd1);
        if (dly > 0 && blk) begin
            for (int i = 0; i < dly; i++) begin
                if (i == 0) begin
                    issue_valid = 1'b1; issue_rd = rd ^ 5'h1f;
                    issue_chk_en = !chk; issue_exp_last = !exl;
                end
                @(negedge clk);
                issue_valid = 1'b0;
                check("R4 waiting holds", {29'd0, stall, s_tready, done}, 32'b110);
            end
        end
        if (arrives) begin
            s_tvalid = 1'b1; s_tdata = d; s_tlast = lst;
        end
        @(negedge clk);
        s_tvalid = 1'b0;
        check("R3 done pulse", {31'd0, done}, 32'd1);
        check("R10 done_rd kept", {27'd0, done_rd}, {27'd0, rd});
        check("R5 nodata flag", {31'd0, done_nodata}, {31'd0, !arrives});
        check("R9 R3 data word", done_data, arrives ? d : 32'd0);
        check("R6 R7 R8 exc_valid", {31'd0, exc_valid}, {31'd0, xc});
        check("R6 R7 R8 exc_cause", {30'd0, exc_cause}, {30'd0, cause});
        check("R2 tready drops at completion", {31'd0, s_tready}, 32'd0);
        if (!arrives) begin
            s_tvalid = 1'b1; s_tlast = 1'b1;
            @(negedge clk);
            check("R5 no beat consumed", {30'd0, s_tready, done}, 32'd0);
            s_tvalid = 1'b0;
        end else begin
            @(negedge clk);
            check("R3 single-cycle done", {31'd0, done}, 32'd0);
        end
    endtask

    initial begin
        for (int c = 0; c < 20000; c++) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset outputs", {27'd0, s_tready, stall, done, exc_cause}, 32'd0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 after reset", {28'd0, s_tready, stall, done, exc_valid}, 32'd0);
        for (int k = 0; k < 32; k++) begin
            bit blk, chk, exl, lst;
            int dly;
            blk = k[4]; chk = k[3]; exl = k[2]; lst = k[1];
            dly = k[0] ? 2 : 0;
            run_op(blk, chk, exl, lst, dly, 32'hA500_0000 ^ (k * 32'h0101_0103), 5'(k + 1));
        end
        @(negedge clk);
        check("R2 idle tready low", {31'd0, s_tready}, 32'd0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule